// File: doc/BRIEF.md
# Masked Address Range Decoder

This block decides which of a set of address windows an incoming read or write falls into. Each window is described by a base word and a mask word. The upper part of each word, bits 63:6, selects address bits. Windows therefore start and end on 64-byte boundaries. The low four bits of the mask act as switches that make the request's access attributes part of the comparison, and the base word holds the attribute value each switch expects. A request is presented for one cycle. One cycle later the block reports exactly one of three outcomes: a single matching window with its index, a decode error when no window matches, or a multi-hit. A multi-hit also raises a sticky fatal interrupt.

The windows are set up through a small word-wide configuration port. Each window has a base slot and a mask slot, and one more slot holds the interrupt status, which is cleared by writing a one. A build-time parameter turns the windows into constants. In that mode they read back their parameter values and configuration writes to them have no effect.

Top module: `addr_range_decoder`

## Requirements
- R1: Window i matches address bits 63:6 when (address AND mask[i]) equals base[i] over bits 63:6. Address bits 5:0 never take part in the comparison. A base bit that is 1 where its mask bit is 0 makes the window unmatchable.
- R2: Mask bits 3, 2, 1 and 0 enable checks on, in that order, the read flag (1 = read, 0 = write), the instruction-fetch flag, the non-secure flag and the privileged flag. When a mask bit is enabled, the window matches only if the request flag equals the base bit in the same position. Bits 5:4 never affect matching.
- R3: When exactly one window matches a request, the block gives rsp_valid=1, rsp_hit=1 and rsp_idx set to that window, in the cycle after req_valid.
- R4: When no window matches, the block gives rsp_valid=1, rsp_decerr=1 and rsp_hit=0 in the cycle after the request.
- R5: When two or more windows match, the block gives rsp_multi=1, rsp_hit=0, rsp_decerr=0 and rsp_idx set to the lowest matching index. fatal_irq is set at the same clock edge.
- R6: fatal_irq stays set until reset, or until a configuration write of data bit 0 = 1 to status slot 2*NUM_RANGES. A multi-hit at the same edge wins over the clear. The status slot reads back fatal_irq in bit 0.
- R7: Configuration slot 2*i holds base[i] and slot 2*i+1 holds mask[i]. In programmable mode a write stores the full 64-bit word, and the word reads back on cfg_rdata in the same cycle.
- R8: After reset, every base reads 0, every mask reads MASK_RST in bits 63:6 and 0 in bits 5:0, fatal_irq is 0 and rsp_valid is 0.
- R9: With PROGRAMMABLE=0, the windows always read back and match FIXED_BASE and FIXED_MASK, and configuration writes to window slots change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_addr | input | 64 | Request address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_instr | input | 1 | Instruction fetch |
| req_nonsec | input | 1 | Non-secure access |
| req_priv | input | 1 | Privileged access |
| rsp_valid | output | 1 | Result present |
| rsp_hit | output | 1 | Exactly one window matched |
| rsp_idx | output | IDX_W | Lowest matching window |
| rsp_decerr | output | 1 | No window matched |
| rsp_multi | output | 1 | More than one window matched |
| fatal_irq | output | 1 | Sticky overlap interrupt |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | CA_W | Configuration slot |
| cfg_wdata | input | 64 | Configuration write data |
| cfg_rdata | output | 64 | Configuration read data, combinational |

## Verification
The assertions assume that req_valid is a plain one-cycle-or-longer strobe with stable attributes while it is high. They also assume that status clears arrive only through the configuration port, so that the interrupt can change only by a multi-hit or by a clear. The bench drives every input half a cycle away from the sampling edge. It keeps configuration slots within 0 to 2*NUM_RANGES. It never issues a clear in the same cycle as a request that it expects to overlap, except where the priority of set over clear is the point of the step.

// File: rtl/ard_pkg.sv
package ard_pkg;

  localparam int AW        = 64;
  localparam int LINE_BITS = 6;
  localparam int ATTR_BITS = 4;

  // Attribute order equals the enable-bit order in the mask word.
  typedef struct packed {
    logic rd;      // bit 3
    logic instr;   // bit 2
    logic nonsec;  // bit 1
    logic priv;    // bit 0
  } acc_attr_t;

  function automatic logic line_match(input logic [AW-1:0] addr,
                                      input logic [AW-1:0] base,
                                      input logic [AW-1:0] mask);
    return (addr[AW-1:LINE_BITS] & mask[AW-1:LINE_BITS]) == base[AW-1:LINE_BITS];
  endfunction

  function automatic logic attr_match(input acc_attr_t     attr,
                                      input logic [AW-1:0] base,
                                      input logic [AW-1:0] mask);
    logic [ATTR_BITS-1:0] diff;
    diff = attr ^ base[ATTR_BITS-1:0];
    return (diff & mask[ATTR_BITS-1:0]) == '0;
  endfunction

  function automatic logic range_hit(input logic [AW-1:0] addr,
                                     input acc_attr_t     attr,
                                     input logic [AW-1:0] base,
                                     input logic [AW-1:0] mask);
    return line_match(addr, base, mask) & attr_match(attr, base, mask);
  endfunction

endpackage

// File: rtl/ard_entries.sv
module ard_entries #(
  parameter int                          NUM_RANGES   = 4,
  parameter bit                          PROGRAMMABLE = 1'b1,
  parameter logic [57:0]                 MASK_RST     = 58'h3FFFFFF800,
  parameter logic [NUM_RANGES*64-1:0]    FIXED_BASE   = '0,
  parameter logic [NUM_RANGES*64-1:0]    FIXED_MASK   = '0,
  localparam int                         IDX_W        = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               wr_en,
  input  logic [IDX_W-1:0]                   wr_idx,
  input  logic                               wr_is_mask,
  input  logic [63:0]                        wr_data,
  output logic [NUM_RANGES-1:0][63:0]        base_q,
  output logic [NUM_RANGES-1:0][63:0]        mask_q
);

  generate
    if (PROGRAMMABLE) begin : g_prog
      for (genvar i = 0; i < NUM_RANGES; i++) begin : g_ent
        logic sel_this;
        assign sel_this = wr_en && (wr_idx == IDX_W'(i));
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) begin
            base_q[i] <= '0;
            mask_q[i] <= {MASK_RST, 6'b0};
          end else if (sel_this) begin
            if (wr_is_mask) mask_q[i] <= wr_data;
            else            base_q[i] <= wr_data;
          end
        end
      end
    end else begin : g_fixed
      logic unused_wr;
      assign unused_wr = ^{clk, rst_n, wr_en, wr_idx, wr_is_mask, wr_data};
      for (genvar i = 0; i < NUM_RANGES; i++) begin : g_ent
        assign base_q[i] = FIXED_BASE[i*64 +: 64];
        assign mask_q[i] = FIXED_MASK[i*64 +: 64];
      end
    end
  endgenerate

endmodule

// File: rtl/ard_match.sv
module ard_match #(
  parameter int NUM_RANGES = 4
) (
  input  logic [63:0]                  addr,
  input  ard_pkg::acc_attr_t           attr,
  input  logic [NUM_RANGES-1:0][63:0]  base_q,
  input  logic [NUM_RANGES-1:0][63:0]  mask_q,
  output logic [NUM_RANGES-1:0]        hit_vec
);

  for (genvar i = 0; i < NUM_RANGES; i++) begin : g_cmp
    assign hit_vec[i] = ard_pkg::range_hit(addr, attr, base_q[i], mask_q[i]);
  end

endmodule

// File: rtl/ard_resolve.sv
module ard_resolve #(
  parameter int NUM_RANGES = 4,
  localparam int IDX_W = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1,
  localparam int CNT_W = $clog2(NUM_RANGES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [NUM_RANGES-1:0] hit_vec,
  input  logic                  clr_evt,
  output logic                  rsp_valid,
  output logic                  rsp_hit,
  output logic [IDX_W-1:0]      rsp_idx,
  output logic                  rsp_decerr,
  output logic                  rsp_multi,
  output logic                  fatal_irq
);

  logic [CNT_W-1:0] hit_cnt;
  logic [IDX_W-1:0] first_idx;
  logic             any_hit;
  logic             multi_hit;
  logic             single_hit;

  always_comb begin
    hit_cnt   = '0;
    first_idx = '0;
    for (int i = NUM_RANGES - 1; i >= 0; i--) begin
      if (hit_vec[i]) begin
        hit_cnt   = hit_cnt + 1'b1;
        first_idx = IDX_W'(i);
      end
    end
  end

  assign any_hit    = |hit_vec;
  assign multi_hit  = hit_cnt > CNT_W'(1);
  assign single_hit = any_hit && !multi_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_hit    <= 1'b0;
      rsp_idx    <= '0;
      rsp_decerr <= 1'b0;
      rsp_multi  <= 1'b0;
    end else begin
      rsp_valid  <= req_valid;
      rsp_hit    <= req_valid && single_hit;
      rsp_decerr <= req_valid && !any_hit;
      rsp_multi  <= req_valid && multi_hit;
      rsp_idx    <= req_valid ? first_idx : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       fatal_irq <= 1'b0;
    else if (req_valid && multi_hit)  fatal_irq <= 1'b1;
    else if (clr_evt)                 fatal_irq <= 1'b0;
  end

  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R4
  outcome_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot({rsp_hit, rsp_decerr, rsp_multi}));

  // R4
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_valid |-> !(rsp_hit || rsp_decerr || rsp_multi));

  // R5
  multi_raises_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_multi |-> fatal_irq);

  // R6
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fatal_irq && !clr_evt) |=> fatal_irq);

  // R6
  irq_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fatal_irq) |-> rsp_multi);

endmodule

// File: rtl/addr_range_decoder.sv
module addr_range_decoder #(
  parameter int                       NUM_RANGES   = 4,
  parameter bit                       PROGRAMMABLE = 1'b1,
  parameter logic [57:0]              MASK_RST     = 58'h3FFFFFF800,
  parameter logic [NUM_RANGES*64-1:0] FIXED_BASE   = '0,
  parameter logic [NUM_RANGES*64-1:0] FIXED_MASK   = {NUM_RANGES{MASK_RST, 6'b0}},
  localparam int IDX_W     = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1,
  localparam int CA_W      = $clog2(2 * NUM_RANGES + 1),
  localparam int STAT_SLOT = 2 * NUM_RANGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [63:0]       req_addr,
  input  logic              req_read,
  input  logic              req_instr,
  input  logic              req_nonsec,
  input  logic              req_priv,
  output logic              rsp_valid,
  output logic              rsp_hit,
  output logic [IDX_W-1:0]  rsp_idx,
  output logic              rsp_decerr,
  output logic              rsp_multi,
  output logic              fatal_irq,
  input  logic              cfg_we,
  input  logic [CA_W-1:0]   cfg_addr,
  input  logic [63:0]       cfg_wdata,
  output logic [63:0]       cfg_rdata
);

  logic [NUM_RANGES-1:0][63:0] base_q;
  logic [NUM_RANGES-1:0][63:0] mask_q;
  logic [NUM_RANGES-1:0]       hit_vec;
  ard_pkg::acc_attr_t          req_attr;
  logic                        slot_is_entry;
  logic                        slot_is_stat;
  logic [IDX_W-1:0]            slot_idx;
  logic                        entry_wr;
  logic                        clr_evt;

  assign req_attr = '{rd: req_read, instr: req_instr, nonsec: req_nonsec, priv: req_priv};

  assign slot_is_entry = cfg_addr < CA_W'(STAT_SLOT);
  assign slot_is_stat  = cfg_addr == CA_W'(STAT_SLOT);
  assign slot_idx      = IDX_W'(cfg_addr >> 1);
  assign entry_wr      = cfg_we && slot_is_entry;
  assign clr_evt       = cfg_we && slot_is_stat && cfg_wdata[0];

  ard_entries #(
    .NUM_RANGES  (NUM_RANGES),
    .PROGRAMMABLE(PROGRAMMABLE),
    .MASK_RST    (MASK_RST),
    .FIXED_BASE  (FIXED_BASE),
    .FIXED_MASK  (FIXED_MASK)
  ) u_entries (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (entry_wr),
    .wr_idx    (slot_idx),
    .wr_is_mask(cfg_addr[0]),
    .wr_data   (cfg_wdata),
    .base_q    (base_q),
    .mask_q    (mask_q)
  );

  ard_match #(.NUM_RANGES(NUM_RANGES)) u_match (
    .addr   (req_addr),
    .attr   (req_attr),
    .base_q (base_q),
    .mask_q (mask_q),
    .hit_vec(hit_vec)
  );

  ard_resolve #(.NUM_RANGES(NUM_RANGES)) u_resolve (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .hit_vec   (hit_vec),
    .clr_evt   (clr_evt),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_idx   (rsp_idx),
    .rsp_decerr(rsp_decerr),
    .rsp_multi (rsp_multi),
    .fatal_irq (fatal_irq)
  );

  always_comb begin
    cfg_rdata = '0;
    if (slot_is_stat)       cfg_rdata = {63'b0, fatal_irq};
    else if (slot_is_entry) cfg_rdata = cfg_addr[0] ? mask_q[slot_idx] : base_q[slot_idx];
  end

  // R7
  base_write_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (PROGRAMMABLE && entry_wr && !cfg_addr[0]) |=> (base_q[$past(slot_idx)] == $past(cfg_wdata)));

  // R6
  clear_drops_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !(req_valid && (hit_vec & (hit_vec - 1'b1)) != '0)) |=> !fatal_irq);

endmodule

// File: tb/sim_addr_range_decoder.sv
`timescale 1ns/1ps
module sim_addr_range_decoder;

  localparam int N    = 4;
  localparam int CA_W = $clog2(2 * N + 1);
  localparam logic [57:0] MRST = 58'h3FFFFFF800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic        req_valid = 0, req_read = 0, req_instr = 0, req_nonsec = 0, req_priv = 0;
  logic [63:0] req_addr = '0;
  logic        cfg_we = 0;
  logic [CA_W-1:0] cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic        rsp_valid, rsp_hit, rsp_decerr, rsp_multi, fatal_irq;
  logic [1:0]  rsp_idx;
  logic [63:0] cfg_rdata;

  addr_range_decoder #(.NUM_RANGES(N)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_read(req_read), .req_instr(req_instr), .req_nonsec(req_nonsec), .req_priv(req_priv),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_idx(rsp_idx), .rsp_decerr(rsp_decerr),
    .rsp_multi(rsp_multi), .fatal_irq(fatal_irq), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata));

  // read-only instance, two fixed windows
  logic        ro_req_valid = 0;
  logic [63:0] ro_req_addr = '0;
  logic        ro_cfg_we = 0;
  logic [2:0]  ro_cfg_addr = '0;
  logic [63:0] ro_cfg_wdata = '0;
  logic        ro_valid, ro_hit, ro_decerr, ro_multi, ro_irq;
  logic        ro_idx;
  logic [63:0] ro_rdata;

  addr_range_decoder #(
    .NUM_RANGES(2), .PROGRAMMABLE(1'b0),
    .FIXED_BASE({64'h0000_0000_6000_0000, 64'h0000_0000_5000_0000}),
    .FIXED_MASK({64'hFFFF_FFFF_F000_0000, 64'hFFFF_FFFF_F000_0000})
  ) u_ro (
    .clk(clk), .rst_n(rst_n), .req_valid(ro_req_valid), .req_addr(ro_req_addr),
    .req_read(1'b1), .req_instr(1'b0), .req_nonsec(1'b0), .req_priv(1'b1),
    .rsp_valid(ro_valid), .rsp_hit(ro_hit), .rsp_idx(ro_idx), .rsp_decerr(ro_decerr),
    .rsp_multi(ro_multi), .fatal_irq(ro_irq), .cfg_we(ro_cfg_we), .cfg_addr(ro_cfg_addr),
    .cfg_wdata(ro_cfg_wdata), .cfg_rdata(ro_rdata));

  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // ---------------- behavioural reference model of u0 ----------------
  logic [63:0] mb [N];
  logic [63:0] mm [N];
  bit e_valid, e_hit, e_decerr, e_multi, e_fatal;
  int e_idx;

  function automatic bit m_hit(logic [63:0] a, logic [3:0] at, logic [63:0] b, logic [63:0] m);
    for (int k = 6; k < 64; k++) if ((m[k] & a[k]) !== b[k]) return 0;
    for (int k = 0; k < 4; k++) if (m[k] && (at[k] !== b[k])) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin : mdl
    int n;
    int first;
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin mb[i] = '0; mm[i] = {MRST, 6'b0}; end
      e_valid = 0; e_hit = 0; e_decerr = 0; e_multi = 0; e_fatal = 0; e_idx = 0;
    end else begin
      n = 0; first = 0;
      for (int i = N - 1; i >= 0; i--)
        if (m_hit(req_addr, {req_read, req_instr, req_nonsec, req_priv}, mb[i], mm[i])) begin
          n++; first = i;
        end
      e_valid  = req_valid;
      e_hit    = req_valid && n == 1;
      e_decerr = req_valid && n == 0;
      e_multi  = req_valid && n > 1;
      e_idx    = req_valid ? first : 0;
      if (req_valid && n > 1) e_fatal = 1;
      else if (cfg_we && cfg_addr == CA_W'(2 * N) && cfg_wdata[0]) e_fatal = 0;
      if (cfg_we && cfg_addr < CA_W'(2 * N)) begin
        if (cfg_addr[0]) mm[cfg_addr >> 1] = cfg_wdata;
        else             mb[cfg_addr >> 1] = cfg_wdata;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(rsp_valid == e_valid, "R3 valid", 64'(rsp_valid), 64'(e_valid));
      chk(rsp_hit == e_hit, "R3 hit", 64'(rsp_hit), 64'(e_hit));
      chk(rsp_decerr == e_decerr, "R4 decerr", 64'(rsp_decerr), 64'(e_decerr));
      chk(rsp_multi == e_multi, "R5 multi", 64'(rsp_multi), 64'(e_multi));
      chk(int'(rsp_idx) == e_idx, "R5 idx", 64'(rsp_idx), 64'(e_idx));
      chk(fatal_irq == e_fatal, "R6 fatal", 64'(fatal_irq), 64'(e_fatal));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic cfg_wr(input int slot, input logic [63:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_addr = CA_W'(slot); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic cfg_rd_chk(input int slot, input logic [63:0] exp, input string req);
    cfg_addr = CA_W'(slot);
    #1;
    chk(cfg_rdata === exp, req, cfg_rdata, exp);
  endtask

  // issue one request; returns at the negedge where the result is visible
  task automatic lookup(input logic [63:0] a, input bit rd, input bit ins, input bit ns, input bit pv);
    @(negedge clk);
    req_valid = 1; req_addr = a; req_read = rd; req_instr = ins; req_nonsec = ns; req_priv = pv;
    @(negedge clk);
    req_valid = 0;
  endtask

  // watchdog
  int cyc = 0;
  always @(posedge clk) begin
    cyc++;
    if (cyc > 5000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=<5000", cyc);
      finish_up();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state
    chk(rsp_valid == 0 && fatal_irq == 0, "R8 reset outputs", {fatal_irq, rsp_valid}, 0);
    cfg_rd_chk(0, 64'h0, "R8 base reset");
    cfg_rd_chk(3, {MRST, 6'b0}, "R8 mask reset");
    rst_n = 1;

    // R5: default masks make every window match a low address
    lookup(64'h0, 1, 0, 0, 1);
    chk(rsp_multi == 1 && rsp_idx == 0, "R5 reset overlap", {rsp_multi, rsp_idx}, 3'b100);
    chk(fatal_irq == 1, "R5 irq set", 64'(fatal_irq), 1);
    cfg_rd_chk(2 * N, 64'h1, "R6 status reads irq");

    // program windows (R7)
    cfg_wr(0, 64'h0000_0000_1000_0000); cfg_wr(1, 64'hFFFF_FFFF_FFF0_0000);
    cfg_wr(2, 64'h0000_0000_2000_0008); cfg_wr(3, 64'hFFFF_FFFF_FFF0_0008);
    cfg_wr(4, 64'h0000_0000_3000_0001); cfg_wr(5, 64'hFFFF_FFFF_FFFF_F003);
    cfg_wr(6, 64'h0000_0000_3000_0000); cfg_wr(7, 64'hFFFF_FFFF_FFF0_0004);
    cfg_rd_chk(5, 64'hFFFF_FFFF_FFFF_F003, "R7 mask readback");
    cfg_rd_chk(4, 64'h0000_0000_3000_0001, "R7 base readback");
    chk(fatal_irq == 1, "R6 irq held through writes", 64'(fatal_irq), 1);

    // R6 clear
    cfg_wr(2 * N, 64'h1);
    chk(fatal_irq == 0, "R6 clear", 64'(fatal_irq), 0);

    // R1 / R3 single hit, low bits ignored
    lookup(64'h0000_0000_1000_0040, 0, 0, 1, 0);
    chk(rsp_hit == 1 && rsp_idx == 0, "R1 hit window0", {rsp_hit, rsp_idx}, 3'b100);
    lookup(64'h0000_0000_100F_FFFF, 1, 1, 0, 0);
    chk(rsp_hit == 1 && rsp_idx == 0, "R1 low bits ignored", {rsp_hit, rsp_idx}, 3'b100);
    // R4 miss
    lookup(64'h0000_0000_1010_0000, 1, 0, 0, 1);
    chk(rsp_decerr == 1 && rsp_hit == 0, "R4 miss", {rsp_decerr, rsp_hit}, 2'b10);
    // R2 read-only window
    lookup(64'h0000_0000_2000_0100, 1, 0, 0, 0);
    chk(rsp_hit == 1 && rsp_idx == 1, "R2 read allowed", {rsp_hit, rsp_idx}, 3'b101);
    lookup(64'h0000_0000_2000_0100, 0, 0, 0, 0);
    chk(rsp_decerr == 1, "R2 write rejected", 64'(rsp_decerr), 1);
    // R2 instruction fetch, secure privileged: only window 2
    lookup(64'h0000_0000_3000_0000, 1, 1, 0, 1);
    chk(rsp_hit == 1 && rsp_idx == 2, "R2 fetch to window2", {rsp_hit, rsp_idx}, 3'b110);
    // R2 non-secure fetch matches neither
    lookup(64'h0000_0000_3000_0000, 1, 1, 1, 1);
    chk(rsp_decerr == 1, "R2 nonsec rejected", 64'(rsp_decerr), 1);
    // R2 unprivileged rejected by window2, data -> window3 only
    lookup(64'h0000_0000_3000_0000, 1, 0, 0, 0);
    chk(rsp_hit == 1 && rsp_idx == 3, "R2 user data to window3", {rsp_hit, rsp_idx}, 3'b111);
    // R5 double hit
    lookup(64'h0000_0000_3000_0000, 0, 0, 0, 1);
    chk(rsp_multi == 1 && rsp_idx == 2 && fatal_irq == 1, "R5 double hit", {rsp_multi, rsp_idx, fatal_irq}, 4'b1101);
    // R6 sticky across a clean lookup
    lookup(64'h0000_0000_1000_0000, 1, 0, 0, 0);
    chk(fatal_irq == 1 && rsp_hit == 1, "R6 sticky", {fatal_irq, rsp_hit}, 2'b11);
    // R6 clear with data bit0 = 0 has no effect
    cfg_wr(2 * N, 64'h2);
    chk(fatal_irq == 1, "R6 zero write keeps irq", 64'(fatal_irq), 1);
    // R6 set wins over simultaneous clear
    @(negedge clk);
    req_valid = 1; req_addr = 64'h0000_0000_3000_0000; req_read = 0; req_instr = 0; req_nonsec = 0; req_priv = 1;
    cfg_we = 1; cfg_addr = CA_W'(2 * N); cfg_wdata = 64'h1;
    @(negedge clk);
    req_valid = 0; cfg_we = 0;
    chk(fatal_irq == 1, "R6 set beats clear", 64'(fatal_irq), 1);
    cfg_wr(2 * N, 64'h1);
    chk(fatal_irq == 0, "R6 cleared", 64'(fatal_irq), 0);

    // R1 base bit outside mask makes window unmatchable
    cfg_wr(0, 64'h0000_0000_1000_0040);
    lookup(64'h0000_0000_1000_0040, 1, 0, 0, 0);
    chk(rsp_decerr == 1, "R1 stray base bit", 64'(rsp_decerr), 1);
    // R2 reserved bits 5:4 ignored
    cfg_wr(0, 64'h0000_0000_1000_0030); cfg_wr(1, 64'hFFFF_FFFF_FFF0_0030);
    lookup(64'h0000_0000_1000_0000, 0, 1, 1, 0);
    chk(rsp_hit == 1 && rsp_idx == 0, "R2 reserved bits ignored", {rsp_hit, rsp_idx}, 3'b100);

    // R9 read-only instance
    ro_cfg_addr = 3'd0; #1;
    chk(ro_rdata === 64'h0000_0000_5000_0000, "R9 fixed base", ro_rdata, 64'h5000_0000);
    @(negedge clk);
    ro_cfg_we = 1; ro_cfg_addr = 3'd0; ro_cfg_wdata = 64'h0;
    @(negedge clk);
    ro_cfg_we = 1; ro_cfg_addr = 3'd3; ro_cfg_wdata = 64'h0;
    @(negedge clk);
    ro_cfg_we = 0;
    ro_cfg_addr = 3'd0; #1;
    chk(ro_rdata === 64'h0000_0000_5000_0000, "R9 base write ignored", ro_rdata, 64'h5000_0000);
    ro_cfg_addr = 3'd3; #1;
    chk(ro_rdata === 64'hFFFF_FFFF_F000_0000, "R9 mask write ignored", ro_rdata, 64'hFFFF_FFFF_F000_0000);
    @(negedge clk);
    ro_req_valid = 1; ro_req_addr = 64'h0000_0000_6ABC_0000;
    @(negedge clk);
    ro_req_valid = 0;
    chk(ro_hit == 1 && ro_idx == 1, "R9 fixed window match", {ro_hit, ro_idx}, 2'b11);
    @(negedge clk);
    ro_req_valid = 1; ro_req_addr = 64'h0000_0000_7000_0000;
    @(negedge clk);
    ro_req_valid = 0;
    chk(ro_decerr == 1, "R9 fixed window miss", 64'(ro_decerr), 1);

    repeat (2) @(negedge clk);
    finish_up();
  end

endmodule